// File: doc/BRIEF.md
# Bit-Serial Unsigned Multiplier with Parallel Coefficient

This block multiplies two N-bit unsigned numbers. One operand is loaded in parallel when an operation starts. The other operand is fed in one bit per clock, least significant bit first, and the 2N-bit product comes out one bit per clock, also least significant bit first. The array holds one cell per bit of the parallel operand. Each cell forms a single-bit partial product and adds it into a running sum that moves one cell toward the output end every cycle, so the structure looks like a transposed FIR filter with one-bit taps. The serial input and the serial output both sit at cell 0.

Every full adder is built from three-input majority gates and inverters only. AND is a majority gate with one input tied low. The parameter `MODE` selects how carries travel. In carry-delay mode, each cell keeps its own carry and uses it on the next cycle. In carry-shift mode, each carry passes down to the neighbouring cell after two register stages. A single serial adder at the output end then merges the sum stream and the carry stream. The two modes have fixed latencies of one and two cycles.

An operation is started with a one-cycle pulse. The block then ignores its serial input after the N operand bits and feeds zeros into the array, so the upper half of the product drains out. A new operation may start in the cycle that carries the last product bit.

Top module: `bitser_mult`

## Requirements
- R1: When `start_i` is high and `busy_o` is low at a clock edge, the block loads `b_i` and takes `a_bit_i` as bit 0 of the serial operand. Bits 1 to N-1 are sampled at the next N-1 edges.
- R2: The valid product bits, read in order, equal bit 0 through bit 2N-1 of the unsigned product a*b. This holds for every operand pair, including zero, all ones and single set bits.
- R3: `prod_valid_o` is high for exactly 2N consecutive cycles per operation.
- R4: With `MODE` = carry-delay, the first valid product bit appears in the cycle right after the start edge.
- R5: With `MODE` = carry-shift, the first valid product bit appears two cycles after the start edge.
- R6: `a_bit_i` has no effect from the N-th edge after the start edge until the operation ends. Zeros are fed to the array instead.
- R7: A `start_i` pulse while `busy_o` is high is ignored. `b_i` at that time does not change the running product, and no extra valid bits appear.
- R8: `busy_o` is high from the start edge until the edge that presents the last product bit. It is low in that last valid cycle, so a new start can be accepted there.
- R9: After reset, `prod_valid_o`, `busy_o` and `prod_bit_o` are all low.
- R10: An accepted start clears all sum and carry state. The result of one operation never depends on the operation before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only when idle |
| b_i | input | N | Parallel operand, captured on an accepted start |
| a_bit_i | input | 1 | Serial operand bit, LSB first |
| prod_bit_o | output | 1 | Serial product bit, LSB first |
| prod_valid_o | output | 1 | Marks the 2N product bits |
| busy_o | output | 1 | Operation in progress |

## Verification
A wrong sum bit in cell j first shows up j cycles later, as a wrong product bit at weight j above the current one. A lost or misrouted carry corrupts the product one weight higher. It then keeps corrupting the upper half until the carry would have been absorbed. So most internal faults show as a mismatch within the current 2N-bit window. Sequencer faults show in the same operation: a valid window of the wrong length or the wrong first cycle, a busy flag that falls at the wrong time, or an upper half polluted by serial input that should be ignored. A failure to clear carries shows only in the next operation, as a non-zero result for a zero operand.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  typedef enum logic {
    CARRY_SHIFT = 1'b0,
    CARRY_DELAY = 1'b1
  } carry_mode_e;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (y & z) | (z & x);
  endfunction

  // cycles from the start edge to the first product bit
  function automatic int unsigned lat_of(input carry_mode_e m);
    return (m == CARRY_DELAY) ? 1 : 2;
  endfunction

endpackage

// File: rtl/bsm_maj_fa.sv
module bsm_maj_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output logic sum_o,
  output logic carry_o
);
  import bsm_pkg::*;

  logic cy, inner;

  // three majority gates, two inverters
  always_comb begin
    cy      = maj3(x_i, y_i, z_i);
    inner   = maj3(x_i, y_i, ~z_i);
    sum_o   = maj3(~cy, z_i, inner);
    carry_o = cy;
  end

endmodule

// File: rtl/bsm_cell.sv
module bsm_cell #(
  parameter bsm_pkg::carry_mode_e MODE = bsm_pkg::CARRY_DELAY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic a_i,
  input  logic b_i,
  input  logic sum_i,
  input  logic carry_i,
  output logic sum_o,
  output logic carry_o
);
  import bsm_pkg::*;

  logic pp, fa_sum, fa_cy;
  logic sum_q, carry_q;

  assign pp = maj3(a_i, b_i, 1'b0);

  bsm_maj_fa u_fa (
    .x_i    (pp),
    .y_i    (sum_i),
    .z_i    (carry_i),
    .sum_o  (fa_sum),
    .carry_o(fa_cy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q   <= 1'b0;
      carry_q <= 1'b0;
    end else if (clr_i) begin
      sum_q   <= 1'b0;
      carry_q <= 1'b0;
    end else if (en_i) begin
      sum_q   <= fa_sum;
      carry_q <= fa_cy;
    end
  end

  assign sum_o = sum_q;

  generate
    if (MODE == CARRY_SHIFT) begin : g_shift
      // second stage keeps the weight aligned one cell down
      logic carry_d2_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     carry_d2_q <= 1'b0;
        else if (clr_i)  carry_d2_q <= 1'b0;
        else if (en_i)   carry_d2_q <= carry_q;
      end
      assign carry_o = carry_d2_q;
      a_r10_clear_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(clr_i) |-> !carry_d2_q);
    end else begin : g_delay
      assign carry_o = carry_q;
    end
  endgenerate

  a_r10_clear_cell: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> (!sum_q && !carry_q));

endmodule

// File: rtl/bsm_seq.sv
module bsm_seq #(
  parameter int N   = 4,
  parameter int LAT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic a_bit_i,
  output logic clr_o,
  output logic en_o,
  output logic a_o,
  output logic busy_o,
  output logic valid_o
);
  localparam int LAST = LAT + 2 * N - 1;
  localparam int CW   = $clog2(LAST + 1) + 1;

  logic [CW-1:0] cnt_q, nxt;
  logic          busy_q, valid_q, a_q, accept;

  assign accept = start_i & ~busy_q;
  assign nxt    = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      a_q     <= 1'b0;
    end else if (accept) begin
      cnt_q   <= '0;
      busy_q  <= 1'b1;
      valid_q <= 1'b0;
      a_q     <= a_bit_i;
    end else if (busy_q) begin
      cnt_q   <= nxt;
      busy_q  <= (nxt != CW'(LAST));
      valid_q <= (nxt >= CW'(LAT));
      a_q     <= (nxt < CW'(N)) ? a_bit_i : 1'b0; // zero fill after N bits
    end else begin
      valid_q <= 1'b0;
      a_q     <= 1'b0;
    end
  end

  assign clr_o   = accept;
  assign en_o    = busy_q;
  assign a_o     = a_q;
  assign busy_o  = busy_q;
  assign valid_o = valid_q;

  a_r7_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  a_r6_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q >= CW'(N - 1)) |=> !a_q);

  a_r3_valid_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !busy_q) |=> !valid_q);

  a_r8_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> valid_q);

  // R5 shares this check through LAT
  a_r4_first_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> (cnt_q == CW'(LAT)));

endmodule

// File: rtl/bitser_mult.sv
module bitser_mult #(
  parameter int                   N    = 4,
  parameter bsm_pkg::carry_mode_e MODE = bsm_pkg::CARRY_DELAY
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [N-1:0] b_i,
  input  logic         a_bit_i,
  output logic         prod_bit_o,
  output logic         prod_valid_o,
  output logic         busy_o
);
  import bsm_pkg::*;

  localparam int LAT = int'(lat_of(MODE));

  logic         clr, en, a_cur;
  logic [N-1:0] b_q;
  logic [N-1:0] sum_w, carry_w, sum_in_w, carry_in_w;

  bsm_seq #(.N(N), .LAT(LAT)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .a_bit_i(a_bit_i),
    .clr_o  (clr),
    .en_o   (en),
    .a_o    (a_cur),
    .busy_o (busy_o),
    .valid_o(prod_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  b_q <= '0;
    else if (clr) b_q <= b_i;
  end

  generate
    for (genvar j = 0; j < N; j++) begin : g_cell
      if (j == N - 1) begin : g_top
        assign sum_in_w[j] = 1'b0;
      end else begin : g_mid
        assign sum_in_w[j] = sum_w[j+1];
      end

      if (MODE == CARRY_DELAY) begin : g_self
        assign carry_in_w[j] = carry_w[j];
      end else if (j == N - 1) begin : g_edge
        assign carry_in_w[j] = 1'b0;
      end else begin : g_down
        assign carry_in_w[j] = carry_w[j+1];
      end

      bsm_cell #(.MODE(MODE)) u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr),
        .en_i   (en),
        .a_i    (a_cur),
        .b_i    (b_q[j]),
        .sum_i  (sum_in_w[j]),
        .carry_i(carry_in_w[j]),
        .sum_o  (sum_w[j]),
        .carry_o(carry_w[j])
      );
    end

    if (MODE == CARRY_SHIFT) begin : g_resolve
      // serial adder merging the sum and carry streams leaving cell 0
      logic res_sum, res_cy, out_q, rc_q;
      bsm_maj_fa u_res (
        .x_i    (sum_w[0]),
        .y_i    (carry_w[0]),
        .z_i    (rc_q),
        .sum_o  (res_sum),
        .carry_o(res_cy)
      );
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          out_q <= 1'b0;
          rc_q  <= 1'b0;
        end else if (clr) begin
          out_q <= 1'b0;
          rc_q  <= 1'b0;
        end else if (en) begin
          out_q <= res_sum;
          rc_q  <= res_cy;
        end
      end
      assign prod_bit_o = out_q;
    end else begin : g_direct
      assign prod_bit_o = sum_w[0];
    end
  endgenerate

  a_r7_b_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(b_q));

  a_r9_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> !prod_valid_o);

endmodule

// File: tb/bsm_lane.sv
module bsm_lane #(
  parameter int                   N    = 4,
  parameter bsm_pkg::carry_mode_e MODE = bsm_pkg::CARRY_DELAY
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_fail,
  output logic done
);
  import bsm_pkg::*;

  localparam int LAT  = (MODE == CARRY_DELAY) ? 1 : 2;
  localparam int LAST = LAT + 2 * N - 1;

  logic         start, a_bit;
  logic [N-1:0] b;
  logic         prod, valid, busy;

  bitser_mult #(.N(N), .MODE(MODE)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .b_i         (b),
    .a_bit_i     (a_bit),
    .prod_bit_o  (prod),
    .prod_valid_o(valid),
    .busy_o      (busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s N=%0d mode=%0d %s: got %0h expected %0h",
               req, N, MODE, what, act, exp);
    end
  endtask

  // called at a negedge; leaves at the negedge of the last valid bit
  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] bv,
                        input logic [63:0] fill, input bit poke, input string tag);
    logic [2*N-1:0] got, expv;
    int  first, nvalid;
    bit  win_ok, busy_ok;
    got = '0; first = -1; nvalid = 0; win_ok = 1; busy_ok = 1;
    start = 1'b1; b = bv; a_bit = a[0];
    for (int k = 0; k <= LAST; k++) begin
      @(negedge clk);
      if (valid) begin
        if (first < 0) first = k;
        if (nvalid < 2 * N) got[nvalid] = prod;
        nvalid++;
      end
      if (valid != (k >= LAT)) win_ok = 0;
      if (busy != (k < LAST)) busy_ok = 0;
      start = poke && (k == 1);
      b     = (poke && k == 1) ? ~bv : bv;
      a_bit = (k + 1 < N) ? a[k+1] : fill[k % 64];
    end
    expv = {{N{1'b0}}, a} * {{N{1'b0}}, bv};
    chk(got == expv, tag, "product", 64'(got), 64'(expv));
    chk(win_ok && nvalid == 2 * N, "R3", "valid count", 64'(nvalid), 64'(2 * N));
    chk(first == LAT, (MODE == CARRY_DELAY) ? "R4" : "R5", "first valid cycle",
        64'(first), 64'(LAT));
    chk(busy_ok, "R8", "busy window", 64'(busy_ok), 64'd1);
  endtask

  initial begin
    logic [N-1:0] ones;
    n_chk = 0; n_fail = 0; done = 1'b0;
    start = 1'b0; a_bit = 1'b0; b = '0;
    ones = '1;
    wait (rst_n === 1'b1);
    @(negedge clk);
    chk(!valid && !busy && !prod, "R9", "reset outputs", {61'd0, valid, busy, prod}, 64'd0);

    run_op(1, ones, '0, 0, "R1");
    run_op('0, '0, '0, 0, "R2");
    run_op(ones, ones, '1, 0, "R6");
    run_op('0, ones, '1, 0, "R10");
    run_op(ones, '0, '1, 0, "R10");
    for (int i = 0; i < N; i++) begin
      run_op(N'(1) << i, ones, '1, 0, "R2");
      run_op(ones, N'(1) << i, {$urandom, $urandom}, 0, "R2");
    end
    run_op(ones, ones, '1, 1, "R7");

    if (N <= 4) begin
      for (int x = 0; x < (1 << N); x++)
        for (int y = 0; y < (1 << N); y++)
          run_op(N'(x), N'(y), {$urandom, $urandom}, ((x ^ y) % 5) == 0,
                 (((x ^ y) % 5) == 0) ? "R7" : "R2");
    end else begin
      for (int r = 0; r < ((N <= 8) ? 400 : 200); r++)
        run_op(N'($urandom), N'($urandom), {$urandom, $urandom}, (r % 7) == 3,
               ((r % 7) == 3) ? "R7" : "R6");
    end

    start = 1'b0;
    @(negedge clk);
    done = 1'b1;
  end

endmodule

// File: tb/sim_bitser_mult.sv
module sim_bitser_mult;
  import bsm_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   c0, c1, c2, c3, c4, c5;
  int   f0, f1, f2, f3, f4, f5;
  logic [5:0] dn;

  always #2 clk = ~clk;

  bsm_lane #(.N(4),  .MODE(CARRY_DELAY)) u_l0 (.clk(clk), .rst_n(rst_n), .n_chk(c0), .n_fail(f0), .done(dn[0]));
  bsm_lane #(.N(4),  .MODE(CARRY_SHIFT)) u_l1 (.clk(clk), .rst_n(rst_n), .n_chk(c1), .n_fail(f1), .done(dn[1]));
  bsm_lane #(.N(8),  .MODE(CARRY_DELAY)) u_l2 (.clk(clk), .rst_n(rst_n), .n_chk(c2), .n_fail(f2), .done(dn[2]));
  bsm_lane #(.N(8),  .MODE(CARRY_SHIFT)) u_l3 (.clk(clk), .rst_n(rst_n), .n_chk(c3), .n_fail(f3), .done(dn[3]));
  bsm_lane #(.N(16), .MODE(CARRY_DELAY)) u_l4 (.clk(clk), .rst_n(rst_n), .n_chk(c4), .n_fail(f4), .done(dn[4]));
  bsm_lane #(.N(16), .MODE(CARRY_SHIFT)) u_l5 (.clk(clk), .rst_n(rst_n), .n_chk(c5), .n_fail(f5), .done(dn[5]));

  initial begin
    int cyc, total, fails;
    cyc = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    while (!(&dn) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    total = c0 + c1 + c2 + c3 + c4 + c5;
    fails = f0 + f1 + f2 + f3 + f4 + f5;
    if (!(&dn)) begin
      total++;
      fails++;
      $display("FAIL watchdog: lanes done %b expected %b", dn, 6'b111111);
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule